// File: doc/BRIEF.md
# Parallel I/O Bank Controller

This block manages a bank of 32 pads. Each pad is owned either by the local general-purpose logic or by one of two internal peripheral functions, A and B. For each pad the block provides output data, output enable, a pull-up request, open-drain drive, an optional input glitch filter and a pin-change interrupt. Software controls all of this through a small synchronous register bus.

Each configuration field is changed through a pair of registers: one sets the bits written as one, the other clears them. A third register reads the field back. Inputs are synchronised and can be filtered. Any change in a pad's accepted level is latched into a status register that clears when it is read. One interrupt line is raised while any latched bit is also enabled in the interrupt mask.

Top module: `pio_bank`

## Requirements
- R1: Six fields are each held in a set/clear/status group at word addresses 3k (set), 3k+1 (clear) and 3k+2 (status), where k=0 is GPIO ownership (1 means GPIO owns the pad), k=1 is output enable, k=2 is pull-up (driven straight onto `pad_pu`), k=3 is the glitch filter, k=4 is open-drain and k=5 is the interrupt mask.
- R2: A write to a set address ORs the written mask into its field. A write to a clear address removes the mask bits from its field. Pads whose mask bit is zero keep their old value. Bit i always refers to pad i.
- R3: After reset, GPIO owns every pad, all outputs are disabled, pull-ups are all on, filter, open-drain and interrupt mask are all off, function A is selected and the output data is zero.
- R4: Writing a mask to address 21 sets output-data bits and writing a mask to address 22 clears them. Address 23 reads the output data. On a GPIO-owned pad without open-drain, `pad_out` follows the data bit and `pad_oe` follows the enable bit.
- R5: Writing to address 18 selects function A for the masked pads and writing to address 19 selects function B. Address 20 reads the selection, with 1 meaning B. The selected function's out/oe drive the pad only while GPIO does not own it; a GPIO-owned pad ignores the selection.
- R6: Address 24 returns the accepted level of every pad, whichever function owns it.
- R7: With open-drain on, `pad_out` is 0 and the pad is driven only when the source value is low. A high value releases the pad (`pad_oe`=0).
- R8: Both rising and falling changes of a pad's accepted level set that pad's bit in the change status register at address 25.
- R9: A read of address 25 returns the latched bits and clears them in the same access. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R10: `irq` is high exactly while some latched change bit is also enabled in the interrupt mask.
- R11: On a filtered pad, a new level is accepted only after it has been stable for two consecutive clocks at the synchroniser output, so a one-clock pulse is dropped. An unfiltered pad accepts every sampled change.
- R12: A change that lands in the same cycle as a status read is not returned by that read. It stays latched for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data / mask |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad drive enables |
| pad_pu | output | 32 | Pad pull-up enables |
| pa_out | input | 32 | Function A output values |
| pa_oe | input | 32 | Function A drive enables |
| pb_out | input | 32 | Function B output values |
| pb_oe | input | 32 | Function B drive enables |
| periph_in | output | 32 | Accepted pad levels for the peripherals |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the write and read strobes are never active together and that every strobe lasts exactly one clock with a stable address. The bench meets this by driving each access from a task that raises one strobe for a single cycle at the falling edge. The edge and filter properties assume that pad inputs change only between clock edges, so the bench drives `pad_in` only at falling edges. Where it needs a one-clock pulse, it holds the new level for exactly one rising edge. The coincident-read case is timed by counting the three flops between a pad change and the status register.

// File: rtl/pio_bank.sv
module pio_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  input  logic [NPINS-1:0] pa_out,
  input  logic [NPINS-1:0] pa_oe,
  input  logic [NPINS-1:0] pb_out,
  input  logic [NPINS-1:0] pb_oe,
  output logic [NPINS-1:0] periph_in,
  output logic             irq
);
  localparam int NCFG = 6;
  localparam logic [AW-1:0] A_OE_SET = AW'(3);
  localparam logic [AW-1:0] A_OE_CLR = AW'(4);
  localparam logic [AW-1:0] A_SELA   = AW'(18);
  localparam logic [AW-1:0] A_SELB   = AW'(19);
  localparam logic [AW-1:0] A_SELST  = AW'(20);
  localparam logic [AW-1:0] A_DSET   = AW'(21);
  localparam logic [AW-1:0] A_DCLR   = AW'(22);
  localparam logic [AW-1:0] A_DST    = AW'(23);
  localparam logic [AW-1:0] A_PIN    = AW'(24);
  localparam logic [AW-1:0] A_ISR    = AW'(25);

  function automatic logic [NPINS-1:0] cfg_rst(input int k);
    return (k == 0 || k == 2) ? '1 : '0;
  endfunction

  logic [NPINS-1:0] cfg [NCFG];
  logic [NPINS-1:0] sel, dout;
  logic [NPINS-1:0] s1, s2, s3, lvl, lvl_d, isr;
  logic [NPINS-1:0] own, oe, pu, flt, od, im;
  logic [NPINS-1:0] src_out, src_oe, rd_mux;
  logic             isr_rd;

  assign own = cfg[0];
  assign oe  = cfg[1];
  assign pu  = cfg[2];
  assign flt = cfg[3];
  assign od  = cfg[4];
  assign im  = cfg[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCFG; k++) cfg[k] <= cfg_rst(k);
    end else if (bus_we) begin
      for (int k = 0; k < NCFG; k++) begin
        if (bus_addr == AW'(3*k))        cfg[k] <= cfg[k] | bus_wdata;
        else if (bus_addr == AW'(3*k+1)) cfg[k] <= cfg[k] & ~bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      dout <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_SELA) sel  <= sel & ~bus_wdata;
      if (bus_addr == A_SELB) sel  <= sel | bus_wdata;
      if (bus_addr == A_DSET) dout <= dout | bus_wdata;
      if (bus_addr == A_DCLR) dout <= dout & ~bus_wdata;
    end
  end

  assign lvl_d  = (~flt & s2) | (flt & ~(s2 ^ s3) & s2) | (flt & (s2 ^ s3) & lvl);
  assign isr_rd = bus_re && (bus_addr == A_ISR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '0;
      s2  <= '0;
      s3  <= '0;
      lvl <= '0;
      isr <= '0;
    end else begin
      s1  <= pad_in;
      s2  <= s1;
      s3  <= s2;
      lvl <= lvl_d;
      isr <= (isr_rd ? '0 : isr) | (lvl_d ^ lvl);
    end
  end

  assign src_out   = (own & dout) | (~own & sel & pb_out) | (~own & ~sel & pa_out);
  assign src_oe    = (own & oe)   | (~own & sel & pb_oe)  | (~own & ~sel & pa_oe);
  assign pad_out   = src_out & ~od;
  assign pad_oe    = src_oe & ~(od & src_out);
  assign pad_pu    = pu;
  assign periph_in = lvl;
  assign irq       = |(isr & im);

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NCFG; k++)
      if (bus_addr == AW'(3*k+2)) rd_mux = cfg[k];
    if (bus_addr == A_SELST) rd_mux = sel;
    if (bus_addr == A_DST)   rd_mux = dout;
    if (bus_addr == A_PIN)   rd_mux = lvl;
    if (bus_addr == A_ISR)   rd_mux = isr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  // R2
  oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OE_SET) |=>
      ((oe & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((oe & ~$past(bus_wdata)) == ($past(oe) & ~$past(bus_wdata))));

  // R2
  oe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OE_CLR) |=>
      ((oe & $past(bus_wdata)) == '0) &&
      ((oe & ~$past(bus_wdata)) == ($past(oe) & ~$past(bus_wdata))));

  // R9
  isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && lvl_d == lvl) |=> (isr == '0));

  // R8
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_d != lvl) |=> ((isr & $past(lvl_d ^ lvl)) == $past(lvl_d ^ lvl)));

  // R11
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flt & (s2 ^ s3)) != '0) |=> ((lvl & $past(flt & (s2 ^ s3))) == ($past(lvl) & $past(flt & (s2 ^ s3)))));
endmodule

// File: tb/pio_bank_bench.sv
module pio_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] OWN_SET = 5'd0, OWN_CLR = 5'd1, OWN_ST = 5'd2;
  localparam logic [4:0] OE_SET = 5'd3, OE_CLR = 5'd4, OE_ST = 5'd5;
  localparam logic [4:0] PU_SET = 5'd6, PU_CLR = 5'd7, PU_ST = 5'd8;
  localparam logic [4:0] FLT_SET = 5'd9, FLT_ST = 5'd11;
  localparam logic [4:0] OD_SET = 5'd12, OD_ST = 5'd14;
  localparam logic [4:0] IM_SET = 5'd15, IM_CLR = 5'd16, IM_ST = 5'd17;
  localparam logic [4:0] SELA = 5'd18, SELB = 5'd19, SEL_ST = 5'd20;
  localparam logic [4:0] D_SET = 5'd21, D_CLR = 5'd22, D_ST = 5'd23;
  localparam logic [4:0] PIN_ST = 5'd24, ISR = 5'd25;

  logic clk = 0, rst_n = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 0, bus_re = 0, irq;
  logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pu, periph_in;
  logic [31:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
  int checks = 0, errors = 0;
  bit done = 0;
  logic re_q = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_bank u_pio_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pa_out(pa_out),
    .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe), .periph_in(periph_in), .irq(irq));

  always @(posedge clk) re_q <= bus_re;

  always @(negedge clk) begin
    if (re_q) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s read: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_addr = a; bus_re = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_re = 0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    chk(pad_oe, 32'h0, "R3");
    chk({31'b0, irq}, 32'h0, "R3");
    chk(pad_pu, 32'hFFFF_FFFF, "R3");
    rd(OWN_ST, 32'hFFFF_FFFF, "R3");
    rd(OE_ST, 32'h0, "R3");
    rd(IM_ST, 32'h0, "R3");
    rd(SEL_ST, 32'h0, "R3");
    // R2 / R1 set-clear groups
    wr(OE_SET, 32'h0F0);
    wr(OE_SET, 32'hF00);
    rd(OE_ST, 32'hFF0, "R2");
    wr(OE_CLR, 32'h300);
    rd(OE_ST, 32'hCF0, "R2");
    chk(pad_oe, 32'hCF0, "R1");
    wr(PU_CLR, 32'h0000_FFFF);
    rd(PU_ST, 32'hFFFF_0000, "R1");
    chk(pad_pu, 32'hFFFF_0000, "R1");
    wr(PU_SET, 32'h0000_FFFF);
    // R4 output data
    wr(D_SET, 32'hA0);
    rd(D_ST, 32'hA0, "R4");
    chk(pad_out, 32'hA0, "R4");
    wr(D_CLR, 32'h20);
    chk(pad_out, 32'h80, "R4");
    // R5 peripheral select
    pa_out = 32'hF; pa_oe = 32'hF;
    pb_out = 32'hFFFF_FFF0; pb_oe = 32'hFFFF_FFF0;
    wr(OWN_CLR, 32'hF);
    rd(OWN_ST, 32'hFFFF_FFF0, "R1");
    chk(pad_out, 32'h8F, "R5");
    chk(pad_oe, 32'hCFF, "R5");
    wr(SELB, 32'h3);
    chk(pad_out, 32'h8C, "R5");
    chk(pad_oe, 32'hCFC, "R5");
    wr(SELA, 32'h1);
    chk(pad_out, 32'h8D, "R5");
    wr(SELB, 32'h100);
    chk(pad_out, 32'h8D, "R5");
    chk(pad_oe, 32'hCFD, "R5");
    rd(SEL_ST, 32'h102, "R5");
    // R6 pin level regardless of owner, R8 edges, R9 clear on read
    @(negedge clk); pad_in = 32'h5A03;
    settle();
    rd(PIN_ST, 32'h5A03, "R6");
    chk(periph_in, 32'h5A03, "R6");
    rd(ISR, 32'h5A03, "R8");
    rd(ISR, 32'h0, "R9");
    @(negedge clk); pad_in = 32'h5A00;
    settle();
    rd(ISR, 32'h3, "R8");
    wr(OWN_SET, 32'hF);
    // R7 open drain
    wr(OD_SET, 32'h80);
    rd(OD_ST, 32'h80, "R1");
    chk(pad_oe, 32'hC70, "R7");
    chk(pad_out, 32'h0, "R7");
    wr(D_CLR, 32'h80);
    chk(pad_oe, 32'hCF0, "R7");
    chk(pad_out, 32'h0, "R7");
    // R10 interrupt
    wr(IM_SET, 32'h20);
    chk({31'b0, irq}, 32'h0, "R10");
    @(negedge clk); pad_in = 32'h5A20;
    settle();
    chk({31'b0, irq}, 32'h1, "R10");
    rd(ISR, 32'h20, "R10");
    chk({31'b0, irq}, 32'h0, "R10");
    @(negedge clk); pad_in = 32'h5E20;
    settle();
    chk({31'b0, irq}, 32'h0, "R10");
    rd(ISR, 32'h400, "R10");
    wr(IM_CLR, 32'h20);
    rd(IM_ST, 32'h0, "R10");
    // R11 glitch filter
    wr(FLT_SET, 32'h40);
    rd(FLT_ST, 32'h40, "R11");
    @(negedge clk); pad_in[6] = 1'b1;
    @(negedge clk); pad_in[6] = 1'b0;
    settle();
    rd(ISR, 32'h0, "R11");
    rd(PIN_ST, 32'h5E20, "R11");
    @(negedge clk); pad_in[7] = 1'b1;
    @(negedge clk); pad_in[7] = 1'b0;
    settle();
    rd(ISR, 32'h80, "R11");
    @(negedge clk); pad_in[6] = 1'b1;
    settle();
    rd(ISR, 32'h40, "R11");
    // R12 change coinciding with status read
    @(negedge clk); pad_in[9] = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_addr = ISR; bus_re = 1;
    exp_q.push_back(32'h0); tag_q.push_back("R12");
    @(negedge clk); bus_re = 0;
    rd(ISR, 32'h200, "R12");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule